// File: doc/BRIEF.md
# Canonical Signed Digit Recoder

This block takes an unsigned binary constant and rewrites it as a vector of signed digits, each digit being 0, +1 or -1. The vector has the same value as the constant, but no two neighbouring digits are both nonzero. A shift-add multiplier that walks this vector needs one add or subtract per nonzero digit, so long runs of ones in the constant cost two operations instead of one per bit.

A constant is presented on `in_word` with a one-cycle `in_valid`. The recoder then walks the word from bit 0 upward, one bit per clock. It keeps a carry, so that the +1 that closes one run of ones can fold into a run sitting directly above it. When the last digit has been produced, it loads the full digit vector and the count of nonzero digits into output registers and pulses `out_done`. Those outputs hold until the next result replaces them. A request that arrives while a conversion is in progress is dropped.

Top module: `csd_recoder`

## Requirements
- R1: Each digit occupies two bits of `out_digits`, with digit i at bits [2i+1:2i]. The code 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. The code 2'b10 never appears.
- R2: The value sum over i of d_i * 2^i of a finished digit vector equals the unsigned value of the accepted word.
- R3: A finished digit vector never has two adjacent nonzero digits.
- R4: A lone 1 whose next higher bit is 0, and which is not reached by a carry, stays +1 at its own position (for example, word 1 gives +1 at digit 0).
- R5: A run of two or more ones with zeros on both sides becomes three things: -1 at the run's lowest bit, 0 across the rest of the run, and +1 one position above its highest bit (for example, 6 gives -1 at digit 1 and +1 at digit 3).
- R6: The +1 produced above one run merges into a run directly above it, and the merged run is recoded again. For example, 441 (0110111001b) gives +1 at digit 9, -1 at digits 6 and 3, and +1 at digit 0.
- R7: A run that reaches the top input bit puts its +1 in the extra digit WIDTH (for example, all ones gives +1 at digit WIDTH and -1 at digit 0).
- R8: `out_nonzero` equals the number of nonzero digits in `out_digits`. It is never larger than the population count of the accepted word.
- R9: `out_done` is a single-cycle pulse that rises exactly WIDTH+1 clock cycles after the edge that accepted `in_valid`.
- R10: An `in_valid` that arrives while a conversion is running, including in its last cycle, is ignored. It produces no extra result and does not change the current one.
- R11: While `rst` is high, and in the first cycle after it, `out_done` is 0 and `out_digits` and `out_nonzero` are 0.
- R12: `out_digits` and `out_nonzero` change only in the cycle in which `out_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Start request, sampled only when idle |
| in_word | input | WIDTH | Unsigned constant to recode |
| out_digits | output | 2*(WIDTH+1) | Signed digit vector, two bits per digit |
| out_nonzero | output | $clog2(WIDTH+2) | Number of nonzero digits |
| out_done | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
The carry is the only state that links one bit to the next, so an error in it shows at the ports in one of three ways. The result has the wrong value. Two nonzero digits sit next to each other. Or a run fails to merge with its neighbour, and the nonzero count comes out above the minimum. Any of these shows in the `out_done` cycle of that conversion. A fault in the step counter shifts the `out_done` pulse away from cycle WIDTH+1, or leaves the digit vector rotated. A fault in the busy gating produces an unexpected extra result, or corrupts the current one, within one conversion time after the intruding request. Each result is compared with an arithmetic model that computes the non-adjacent form in a separate way. The bench covers isolated ones, runs, merged runs, a run that reaches the top bit, zero, and random words.

// File: rtl/csd_recoder_pkg.sv
`timescale 1ns/1ps
package csd_recoder_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } csd_digit_e;
endpackage

// File: rtl/csd_step.sv
`timescale 1ns/1ps
// One recoding step: the current bit plus the incoming carry, looking one bit ahead.
module csd_step
  import csd_recoder_pkg::*;
(
  input  logic       bit_cur,
  input  logic       bit_next,
  input  logic       carry_in,
  output csd_digit_e digit,
  output logic       carry_out,
  output logic       nonzero
);
  logic [1:0] sum;

  always_comb begin
    sum = {1'b0, bit_cur} + {1'b0, carry_in};
    if (sum == 2'd1) begin
      if (bit_next) begin
        // Start of a run (or a carry joining a run): subtract here, carry upward.
        digit     = DIG_NEG;
        carry_out = 1'b1;
      end else begin
        digit     = DIG_POS;
        carry_out = 1'b0;
      end
    end else begin
      digit     = DIG_ZERO;
      carry_out = sum[1];
    end
    nonzero = (digit != DIG_ZERO);
  end
endmodule

// File: rtl/csd_seq_ctrl.sv
`timescale 1ns/1ps
// Accepts a request when idle and then counts WIDTH+1 steps.
module csd_seq_ctrl #(
  parameter int WIDTH = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic busy,
  output logic last
);
  localparam int STEPS = WIDTH + 1;
  localparam int CW    = $clog2(STEPS + 1);

  logic [CW-1:0] step_cnt;

  assign accept = req && !busy;
  assign last   = busy && (step_cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      step_cnt <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csd_recoder.sv
`timescale 1ns/1ps
module csd_recoder
  import csd_recoder_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [WIDTH-1:0]              in_word,
  output logic [2*(WIDTH+1)-1:0]        out_digits,
  output logic [$clog2(WIDTH+2)-1:0]    out_nonzero,
  output logic                          out_done
);
  localparam int ND   = WIDTH + 1;
  localparam int DW   = 2 * ND;
  localparam int CNTW = $clog2(WIDTH + 2);

  logic            accept;
  logic            busy;
  logic            last;
  logic [WIDTH:0]  bits_sr;
  logic            carry_q;
  logic [DW-1:0]   dig_acc;
  logic [CNTW-1:0] nz_acc;

  csd_digit_e      step_digit;
  logic            step_carry;
  logic            step_nz;
  logic [DW-1:0]   dig_next;
  logic [CNTW-1:0] nz_next;

  csd_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .req    (in_valid),
    .accept (accept),
    .busy   (busy),
    .last   (last)
  );

  csd_step step_i (
    .bit_cur   (bits_sr[0]),
    .bit_next  (bits_sr[1]),
    .carry_in  (carry_q),
    .digit     (step_digit),
    .carry_out (step_carry),
    .nonzero   (step_nz)
  );

  // New digit enters at the top; after ND shifts, digit i sits at bits [2i+1:2i].
  assign dig_next = {step_digit, dig_acc[DW-1:2]};
  assign nz_next  = nz_acc + {{(CNTW-1){1'b0}}, step_nz};

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_sr     <= '0;
      carry_q     <= 1'b0;
      dig_acc     <= '0;
      nz_acc      <= '0;
      out_digits  <= '0;
      out_nonzero <= '0;
      out_done    <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (accept) begin
        bits_sr <= {1'b0, in_word};
        carry_q <= 1'b0;
        dig_acc <= '0;
        nz_acc  <= '0;
      end else if (busy) begin
        bits_sr <= {1'b0, bits_sr[WIDTH:1]};
        carry_q <= step_carry;
        dig_acc <= dig_next;
        nz_acc  <= nz_next;
        if (last) begin
          out_digits  <= dig_next;
          out_nonzero <= nz_next;
          out_done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csd_recoder_chk.sv
`timescale 1ns/1ps
module csd_recoder_chk #(
  parameter int WIDTH = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [WIDTH-1:0]           in_word,
  input logic                       busy,
  input logic [2*(WIDTH+1)-1:0]     out_digits,
  input logic [$clog2(WIDTH+2)-1:0] out_nonzero,
  input logic                       out_done
);
  localparam int ND = WIDTH + 1;
  localparam int SW = $clog2(WIDTH + 3);

  logic [SW-1:0]    since;
  logic             tracking;
  logic [WIDTH-1:0] held_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= '0;
      tracking  <= 1'b0;
      held_word <= '0;
    end else if (in_valid && !busy) begin
      since     <= '0;
      tracking  <= 1'b1;
      held_word <= in_word;
    end else if (out_done) begin
      tracking <= 1'b0;
    end else if (tracking) begin
      since <= since + 1'b1;
    end
  end

  function automatic longint dig_value(input logic [2*(WIDTH+1)-1:0] d);
    longint v = 0;
    for (int i = 0; i < ND; i++) begin
      if (d[2*i +: 2] == 2'b01) v += (longint'(1) << i);
      else if (d[2*i +: 2] == 2'b11) v -= (longint'(1) << i);
    end
    return v;
  endfunction

  function automatic bit no_bad_code(input logic [2*(WIDTH+1)-1:0] d);
    for (int i = 0; i < ND; i++) if (d[2*i +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit no_adjacent(input logic [2*(WIDTH+1)-1:0] d);
    for (int i = 0; i < ND - 1; i++)
      if (d[2*i +: 2] != 2'b00 && d[2*i+2 +: 2] != 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int nz_digits(input logic [2*(WIDTH+1)-1:0] d);
    int n = 0;
    for (int i = 0; i < ND; i++) if (d[2*i +: 2] != 2'b00) n++;
    return n;
  endfunction

  a_r1_code_set: assert property (@(posedge clk) disable iff (rst)
    no_bad_code(out_digits));

  a_r2_value_match: assert property (@(posedge clk) disable iff (rst)
    out_done |-> dig_value(out_digits) == longint'(held_word));

  a_r3_non_adjacent: assert property (@(posedge clk) disable iff (rst)
    out_done |-> no_adjacent(out_digits));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (int'(out_nonzero) == nz_digits(out_digits)) &&
                 (int'(out_nonzero) <= $countones(held_word)));

  a_r9_done_latency: assert property (@(posedge clk) disable iff (rst)
    out_done |-> tracking && (since == SW'(WIDTH + 1)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> !out_done && (out_digits == '0) && (out_nonzero == '0));

  a_r12_hold_result: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> $stable(out_digits) && $stable(out_nonzero));
endmodule

bind csd_recoder csd_recoder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .busy        (busy),
  .out_digits  (out_digits),
  .out_nonzero (out_nonzero),
  .out_done    (out_done)
);

// File: tb/csd_recoder_tb_top.sv
`timescale 1ns/1ps
module csd_recoder_tb_top;
  localparam int WIDTH = 12;
  localparam int ND    = WIDTH + 1;
  localparam int DW    = 2 * ND;
  localparam int CNTW  = $clog2(WIDTH + 2);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] in_word = '0;
  logic [DW-1:0]    out_digits;
  logic [CNTW-1:0]  out_nonzero;
  logic             out_done;

  always #2 clk = ~clk;

  csd_recoder #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_digits(out_digits), .out_nonzero(out_nonzero), .out_done(out_done)
  );

  typedef struct {
    logic [WIDTH-1:0] word;
    logic [DW-1:0]    exp_dig;
    int               exp_nz;
    int               t_acc;
    string            tag;
  } item_t;

  item_t         sb_q[$];
  int            checks = 0;
  int            errors = 0;
  int            ncyc = 0;
  logic [DW-1:0] last_dig = '0;
  logic [CNTW-1:0] last_nz = '0;
  logic          prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Non-adjacent form by integer arithmetic: digit = 2 - (v mod 4) when v is odd.
  function automatic logic [DW-1:0] ref_model(input logic [WIDTH-1:0] w);
    longint v = longint'(w);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < ND; i++) begin
      if (v[0]) begin
        if (v[1]) begin r[2*i +: 2] = 2'b11; v = v + 1; end
        else      begin r[2*i +: 2] = 2'b01; v = v - 1; end
      end
      v = v >>> 1;
    end
    return r;
  endfunction

  function automatic int count_nz(input logic [DW-1:0] d);
    int n = 0;
    for (int i = 0; i < ND; i++) if (d[2*i +: 2] != 2'b00) n++;
    return n;
  endfunction

  function automatic longint sd_value(input logic [DW-1:0] d);
    longint v = 0;
    for (int i = 0; i < ND; i++) begin
      if (d[2*i +: 2] == 2'b01) v += (longint'(1) << i);
      else if (d[2*i +: 2] == 2'b11) v -= (longint'(1) << i);
    end
    return v;
  endfunction

  function automatic bit has_adj(input logic [DW-1:0] d);
    for (int i = 0; i < ND - 1; i++)
      if (d[2*i +: 2] != 2'b00 && d[2*i+2 +: 2] != 2'b00) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit has_bad(input logic [DW-1:0] d);
    for (int i = 0; i < ND; i++) if (d[2*i +: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  // Monitor and scoreboard
  always @(negedge clk) begin
    ncyc++;
    if (!rst) begin
      if (out_done) begin
        chk(!prev_done, "R9", "done wider than one cycle", 1, 0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected result", longint'(out_digits), 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(out_digits == it.exp_dig, it.tag, "digit vector",
              longint'(out_digits), longint'(it.exp_dig));
          chk(sd_value(out_digits) == longint'(it.word), "R2", "signed value",
              sd_value(out_digits), longint'(it.word));
          chk(!has_bad(out_digits), "R1", "code 2'b10 present", longint'(out_digits), 0);
          chk(!has_adj(out_digits), "R3", "adjacent nonzero digits", longint'(out_digits), 0);
          chk(int'(out_nonzero) == it.exp_nz, "R8", "nonzero count",
              longint'(out_nonzero), longint'(it.exp_nz));
          chk(int'(out_nonzero) <= $countones(it.word), "R8", "count above popcount",
              longint'(out_nonzero), longint'($countones(it.word)));
          chk(ncyc == it.t_acc + WIDTH + 2, "R9", "done latency",
              longint'(ncyc), longint'(it.t_acc + WIDTH + 2));
        end
        last_dig = out_digits;
        last_nz  = out_nonzero;
      end else begin
        chk(out_digits == last_dig && out_nonzero == last_nz, "R12",
            "outputs changed without done", longint'(out_digits), longint'(last_dig));
      end
    end
    prev_done = out_done;
  end

  task automatic push_item(input logic [WIDTH-1:0] w, input string tag);
    item_t it;
    it.word    = w;
    it.exp_dig = ref_model(w);
    it.exp_nz  = count_nz(it.exp_dig);
    it.t_acc   = ncyc;
    it.tag     = tag;
    sb_q.push_back(it);
  endtask

  task automatic send(input logic [WIDTH-1:0] w, input string tag);
    @(negedge clk); #1;
    push_item(w, tag);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
    wait (sb_q.size() == 0);
  endtask

  // Second request arrives during the busy window, `gap` cycles after the first drops.
  task automatic send_intrude(input logic [WIDTH-1:0] w, input logic [WIDTH-1:0] w2,
                              input int gap);
    @(negedge clk); #1;
    push_item(w, "R10");
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    #1;
    in_word  = w2;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
    wait (sb_q.size() == 0);
    repeat (2 * (WIDTH + 2)) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        chk(out_done == 1'b0 && out_digits == '0 && out_nonzero == '0, "R11",
            "reset outputs", longint'(out_digits), 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_done == 1'b0 && out_digits == '0 && out_nonzero == '0, "R11",
            "after reset", longint'(out_digits), 0);
        send(12'd1,   "R4");
        send(12'd6,   "R5");
        send(12'd441, "R6");
        send(12'h1F9, "R6");
        send(12'hFFF, "R7");
        send(12'h800, "R4");
        send(12'hC00, "R7");
        send(12'd0,   "R2");
        send(12'h555, "R4");
        send(12'h6DB, "R6");
        send_intrude(12'd441, 12'hFFF, 3);
        send_intrude(12'h0F0, 12'h00F, WIDTH);
        for (int k = 0; k < 40; k++) send(WIDTH'($urandom), "R2");
        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R10", "pending results", longint'(sb_q.size()), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog act=timeout exp=completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule